// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

This unit is the execute stage of a small 8-bit controller datapath that also handles 16-bit word arithmetic. Each cycle it takes an operation code, a destination operand, a source operand, an immediate and the current status flags. One clock edge later it presents a result, a new set of four status flags (overflow, negative, carry, zero) and a write-enable. The write-enable tells the surrounding datapath whether the result belongs in the destination register.

Byte operations cover add, add-with-carry, subtract, subtract-with-borrow, compare, add of a sign-extended 4-bit immediate, and the three bitwise operations AND, OR and XOR. Word operations cover add, subtract and compare at full width, add of a sign-extended 4-bit immediate, and mixed-width adds in which a source byte is zero- or sign-extended before it joins a 16-bit destination. Two further operations apply an AND mask or an OR mask from the immediate directly to the incoming flags. The widths are parameters: the word is always twice the byte.

Top module: `psw_alu`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `res_o`=0, `flags_o`=0 and `wr_en_o`=0.
- R2: Every output reflects the inputs present at the previous rising clock edge (one cycle of latency). Flags are packed as bit 3 = V, bit 2 = N, bit 1 = C, bit 0 = Z.
- R3: Byte add (op 0) gives dst+src, and byte add-with-carry (op 1) gives dst+src+C_in, on the low byte. C is set on carry out of bit 7.
- R4: Byte subtract (op 2) gives dst−src, and byte subtract-with-borrow (op 3) gives dst−src−C_in. C is set when a borrow occurs (unsigned minuend smaller than subtrahend plus borrow). Subtracting equal values gives 0 with flags V=0, N=0, C=0, Z=1.
- R5: For arithmetic, V is set when the signed result does not fit the operation width. N copies the result MSB (bit 7 for byte ops, bit 15 for word ops), and Z is set when the result is zero at that width.
- R6: Byte compare (op 4) and word compare (op 11) set flags as the matching subtraction would, but drive `wr_en_o` low. All other arithmetic and logic ops drive it high.
- R7: Byte add-immediate (op 5) and word add-immediate (op 14) sign-extend `imm_i[3:0]` before adding it to the destination.
- R8: Byte AND (op 6), OR (op 7) and XOR (op 8) force V=0 and C=0 whatever the incoming flags are.
- R9: Word add (op 9), subtract (op 10) and compare (op 11) act on all 16 bits, with C taken from bit 15.
- R10: Unsigned mixed add (op 12) zero-extends `src_i[7:0]` and adds it to the 16-bit destination.
- R11: Signed mixed add (op 13) sign-extends `src_i[7:0]` and adds it to the 16-bit destination.
- R12: Flag-mask operations return `flags_i & imm_i[3:0]` (op 15) or `flags_i | imm_i[3:0]` (op 16) on `flags_o`, with `wr_en_o` low.
- R13: For byte operations the upper byte of `dst_i` and `src_i` is ignored, and `res_o[15:8]` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (0 to 16) |
| dst_i | input | 16 | Destination operand |
| src_i | input | 16 | Source operand |
| imm_i | input | 8 | Immediate; low 4 bits used as signed 4-bit value or flag mask |
| flags_i | input | 4 | Incoming flags {V,N,C,Z}; C feeds carry/borrow ops |
| res_o | output | 16 | Registered result |
| flags_o | output | 4 | Registered flags {V,N,C,Z} |
| wr_en_o | output | 1 | Registered write-back enable |

## Verification
The bench builds the unit with its default widths: an 8-bit byte, a 16-bit word and a 4-bit immediate. At those widths every signed and unsigned boundary can be reached with hand-picked operands. These include 0x7F+1 and 0x80−1 for byte overflow, 0x7FFF+1 for word overflow, and 0−1 for word borrow. Sign-extending 0x80 and an immediate of 0x8 into a word exercises the extension paths. Garbage placed in the upper operand bytes during byte operations shows that those bits never reach the result.

// File: rtl/psw_alu_pkg.sv
package psw_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD8   = 5'd0,
    OP_ADDC8  = 5'd1,
    OP_SUB8   = 5'd2,
    OP_SUBC8  = 5'd3,
    OP_CMP8   = 5'd4,
    OP_ADDI8  = 5'd5,
    OP_AND8   = 5'd6,
    OP_OR8    = 5'd7,
    OP_XOR8   = 5'd8,
    OP_ADDW   = 5'd9,
    OP_SUBW   = 5'd10,
    OP_CMPW   = 5'd11,
    OP_ADDUW  = 5'd12,
    OP_ADDSW  = 5'd13,
    OP_ADDIW  = 5'd14,
    OP_FLGAND = 5'd15,
    OP_FLGOR  = 5'd16
  } alu_op_e;

  localparam int FLAG_W = 4;
  localparam int FV = 3;
  localparam int FN = 2;
  localparam int FC = 1;
  localparam int FZ = 0;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         v,
  output logic         n,
  output logic         c,
  output logic         z
);
  logic [W-1:0] b_eff;
  logic         ci;
  logic         co;

  always_comb begin
    b_eff = sub ? ~b : b;
    // For subtraction, cin is a borrow: a - b - cin = a + ~b + !cin
    ci = sub ? ~cin : cin;
    {co, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci};
    c = sub ? ~co : co;
    v = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    n = sum[W-1];
    z = (sum == '0);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import psw_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  bw_sel_e      sel,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (sel)
      BW_AND:  y = a & b;
      BW_OR:   y = a | b;
      BW_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/psw_alu.sv
module psw_alu
  import psw_alu_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int IMM_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [4:0]            op_i,
  input  logic [2*BYTE_W-1:0]   dst_i,
  input  logic [2*BYTE_W-1:0]   src_i,
  input  logic [BYTE_W-1:0]     imm_i,
  input  logic [FLAG_W-1:0]     flags_i,
  output logic [2*BYTE_W-1:0]   res_o,
  output logic [FLAG_W-1:0]     flags_o,
  output logic                  wr_en_o
);
  localparam int WORD_W = 2 * BYTE_W;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  // ---------------- operand selection ----------------
  logic [BYTE_W-1:0] imm_b;
  logic [WORD_W-1:0] imm_w;
  logic [BYTE_W-1:0] ba, bb;
  logic              b_sub, b_cin;
  logic [WORD_W-1:0] wa, wb;
  logic              w_sub;
  bw_sel_e           bw_sel;

  always_comb begin
    imm_b = {{(BYTE_W-IMM_W){imm_i[IMM_W-1]}}, imm_i[IMM_W-1:0]};
    imm_w = {{(WORD_W-IMM_W){imm_i[IMM_W-1]}}, imm_i[IMM_W-1:0]};

    ba    = dst_i[BYTE_W-1:0];
    bb    = (op == OP_ADDI8) ? imm_b : src_i[BYTE_W-1:0];
    b_sub = (op == OP_SUB8) || (op == OP_SUBC8) || (op == OP_CMP8);
    b_cin = ((op == OP_ADDC8) || (op == OP_SUBC8)) ? flags_i[FC] : 1'b0;

    wa = dst_i;
    unique case (op)
      OP_ADDUW: wb = {{BYTE_W{1'b0}}, src_i[BYTE_W-1:0]};
      OP_ADDSW: wb = {{BYTE_W{src_i[BYTE_W-1]}}, src_i[BYTE_W-1:0]};
      OP_ADDIW: wb = imm_w;
      default:  wb = src_i;
    endcase
    w_sub = (op == OP_SUBW) || (op == OP_CMPW);

    unique case (op)
      OP_OR8:  bw_sel = BW_OR;
      OP_XOR8: bw_sel = BW_XOR;
      default: bw_sel = BW_AND;
    endcase
  end

  // ---------------- datapath units ----------------
  logic [BYTE_W-1:0] b_sum;
  logic              b_v, b_n, b_c, b_z;
  logic [WORD_W-1:0] w_sum;
  logic              w_v, w_n, w_c, w_z;
  logic [BYTE_W-1:0] bw_y;

  alu_addsub #(.W(BYTE_W)) u_byte_add (
    .a(ba), .b(bb), .sub(b_sub), .cin(b_cin),
    .sum(b_sum), .v(b_v), .n(b_n), .c(b_c), .z(b_z)
  );

  alu_addsub #(.W(WORD_W)) u_word_add (
    .a(wa), .b(wb), .sub(w_sub), .cin(1'b0),
    .sum(w_sum), .v(w_v), .n(w_n), .c(w_c), .z(w_z)
  );

  alu_bitwise #(.W(BYTE_W)) u_bitwise (
    .a(ba), .b(src_i[BYTE_W-1:0]), .sel(bw_sel), .y(bw_y)
  );

  // ---------------- result / flag select ----------------
  logic [WORD_W-1:0] res_d;
  logic [FLAG_W-1:0] flags_d;
  logic              we_d;

  always_comb begin
    res_d   = '0;
    flags_d = flags_i;
    we_d    = 1'b0;
    unique case (op)
      OP_ADD8, OP_ADDC8, OP_SUB8, OP_SUBC8, OP_ADDI8: begin
        res_d   = {{BYTE_W{1'b0}}, b_sum};
        flags_d = {b_v, b_n, b_c, b_z};
        we_d    = 1'b1;
      end
      OP_CMP8: begin
        flags_d = {b_v, b_n, b_c, b_z};
      end
      OP_AND8, OP_OR8, OP_XOR8: begin
        res_d   = {{BYTE_W{1'b0}}, bw_y};
        flags_d = {1'b0, bw_y[BYTE_W-1], 1'b0, (bw_y == '0)};
        we_d    = 1'b1;
      end
      OP_ADDW, OP_SUBW, OP_ADDUW, OP_ADDSW, OP_ADDIW: begin
        res_d   = w_sum;
        flags_d = {w_v, w_n, w_c, w_z};
        we_d    = 1'b1;
      end
      OP_CMPW: begin
        flags_d = {w_v, w_n, w_c, w_z};
      end
      OP_FLGAND: flags_d = flags_i & imm_i[FLAG_W-1:0];
      OP_FLGOR:  flags_d = flags_i | imm_i[FLAG_W-1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= '0;
      wr_en_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      flags_o <= flags_d;
      wr_en_o <= we_d;
    end
  end

  // ---------------- assertions ----------------
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (res_o == '0 && flags_o == '0 && !wr_en_o));

  a_r6_compare_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CMP8 || op_i == OP_CMPW) |=> !wr_en_o);

  a_r8_logic_vc_clear: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_AND8 || op_i == OP_OR8 || op_i == OP_XOR8)
      |=> (!flags_o[FV] && !flags_o[FC] && wr_en_o));

  a_r13_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (op_i <= OP_XOR8) |=> (res_o[WORD_W-1:BYTE_W] == '0));

  a_r5_zero_flag_word: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADDW || op_i == OP_SUBW || op_i == OP_ADDUW ||
     op_i == OP_ADDSW || op_i == OP_ADDIW)
      |=> (flags_o[FZ] == (res_o == '0)) && (flags_o[FN] == res_o[WORD_W-1]));

  a_r4_self_sub_flags: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_SUB8 && dst_i[BYTE_W-1:0] == src_i[BYTE_W-1:0])
      |=> (flags_o == 4'b0001 && res_o == '0));

  a_r12_mask_no_write: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_FLGAND || op_i == OP_FLGOR) |=> !wr_en_o);

endmodule

// File: tb/tb_psw_alu.sv
module tb_psw_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  op_i;
  logic [15:0] dst_i, src_i;
  logic [7:0]  imm_i;
  logic [3:0]  flags_i;
  logic [15:0] res_o;
  logic [3:0]  flags_o;
  logic        wr_en_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_alu dut (
    .clk(clk), .rst(rst), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
    .imm_i(imm_i), .flags_i(flags_i), .res_o(res_o), .flags_o(flags_o),
    .wr_en_o(wr_en_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge register, sample at next falling edge.
  task automatic apply(input logic [4:0] op, input logic [15:0] d, input logic [15:0] s,
                       input logic [7:0] im, input logic [3:0] f);
    op_i = op; dst_i = d; src_i = s; imm_i = im; flags_i = f;
    @(negedge clk);
  endtask

  task automatic expect_all(input string req, input logic [15:0] r, input logic [3:0] f,
                            input logic we);
    check({req, " result"}, {16'h0, res_o}, {16'h0, r});
    check({req, " flags"}, {28'h0, flags_o}, {28'h0, f});
    check({req, " wr_en"}, {31'h0, wr_en_o}, {31'h0, we});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    apply(5'd0, 16'h1111, 16'h2222, 8'h0, 4'hF);
    expect_all("R1 reset", 16'h0, 4'b0000, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_byte_add;
    apply(5'd0, 16'h00FF, 16'h0001, 8'h0, 4'b0000);
    expect_all("R3 add carry-out", 16'h0000, 4'b0011, 1'b1);
    apply(5'd1, 16'h0010, 16'h0020, 8'h0, 4'b0010);
    expect_all("R3 addc", 16'h0031, 4'b0000, 1'b1);
    apply(5'd0, 16'h007F, 16'h0001, 8'h0, 4'b0000);
    expect_all("R5 add overflow", 16'h0080, 4'b1100, 1'b1);
  endtask

  task automatic t_byte_sub;
    apply(5'd2, 16'h0005, 16'h0007, 8'h0, 4'b0000);
    expect_all("R4 sub borrow", 16'h00FE, 4'b0110, 1'b1);
    apply(5'd2, 16'h005A, 16'h005A, 8'h0, 4'b1111);
    expect_all("R4 self-sub", 16'h0000, 4'b0001, 1'b1);
    apply(5'd3, 16'h0010, 16'h0001, 8'h0, 4'b0010);
    expect_all("R4 subc", 16'h000E, 4'b0000, 1'b1);
    apply(5'd2, 16'h0080, 16'h0001, 8'h0, 4'b0000);
    expect_all("R5 sub overflow", 16'h007F, 4'b1000, 1'b1);
  endtask

  task automatic t_compare;
    apply(5'd4, 16'h0003, 16'h0003, 8'h0, 4'b0000);
    check("R6 cmp8 flags", {28'h0, flags_o}, 32'h1);
    check("R6 cmp8 wr_en", {31'h0, wr_en_o}, 32'h0);
    apply(5'd11, 16'h1234, 16'h1235, 8'h0, 4'b0000);
    check("R6 cmpw flags", {28'h0, flags_o}, 32'h6);
    check("R6 cmpw wr_en", {31'h0, wr_en_o}, 32'h0);
  endtask

  task automatic t_imm;
    apply(5'd5, 16'h0010, 16'hFFFF, 8'hAF, 4'b0000);
    expect_all("R7 byte imm4 -1", 16'h000F, 4'b0010, 1'b1);
    apply(5'd14, 16'h0000, 16'h1234, 8'h08, 4'b0000);
    expect_all("R7 word imm4 -8", 16'hFFF8, 4'b0100, 1'b1);
  endtask

  task automatic t_logic;
    apply(5'd6, 16'h00F0, 16'h003C, 8'h0, 4'b1111);
    expect_all("R8 and", 16'h0030, 4'b0000, 1'b1);
    apply(5'd7, 16'h0080, 16'h0001, 8'h0, 4'b1111);
    expect_all("R8 or", 16'h0081, 4'b0100, 1'b1);
    apply(5'd8, 16'h00AA, 16'h00AA, 8'h0, 4'b1010);
    expect_all("R8 xor", 16'h0000, 4'b0001, 1'b1);
  endtask

  task automatic t_word;
    apply(5'd9, 16'h7FFF, 16'h0001, 8'h0, 4'b0000);
    expect_all("R9 addw overflow", 16'h8000, 4'b1100, 1'b1);
    apply(5'd10, 16'h0000, 16'h0001, 8'h0, 4'b0000);
    expect_all("R9 subw borrow", 16'hFFFF, 4'b0110, 1'b1);
    apply(5'd9, 16'hFFFF, 16'h0001, 8'h0, 4'b0000);
    expect_all("R9 addw carry", 16'h0000, 4'b0011, 1'b1);
  endtask

  task automatic t_mixed;
    apply(5'd12, 16'h1000, 16'hFF80, 8'h0, 4'b0000);
    expect_all("R10 zero-extend", 16'h1080, 4'b0000, 1'b1);
    apply(5'd13, 16'h1000, 16'h0080, 8'h0, 4'b0000);
    expect_all("R11 sign-extend", 16'h0F80, 4'b0010, 1'b1);
  endtask

  task automatic t_flagmask;
    apply(5'd15, 16'h1234, 16'h5678, 8'h05, 4'b1111);
    check("R12 mask and flags", {28'h0, flags_o}, 32'h5);
    check("R12 mask and wr_en", {31'h0, wr_en_o}, 32'h0);
    apply(5'd16, 16'h1234, 16'h5678, 8'h0A, 4'b0000);
    check("R12 mask or flags", {28'h0, flags_o}, 32'hA);
  endtask

  task automatic t_upper_ignored;
    apply(5'd0, 16'hAB01, 16'hCD02, 8'h0, 4'b0000);
    expect_all("R13 upper ignored", 16'h0003, 4'b0000, 1'b1);
  endtask

  task automatic t_latency;
    // R2: set inputs then change them before the edge is sampled? Output must track the
    // value present at the edge and hold until the next edge.
    op_i = 5'd0; dst_i = 16'h0001; src_i = 16'h0001; imm_i = 8'h0; flags_i = 4'h0;
    @(posedge clk); #1;
    check("R2 registered after edge", {16'h0, res_o}, 32'h2);
    dst_i = 16'h0010;
    #1;
    check("R2 holds between edges", {16'h0, res_o}, 32'h2);
    @(negedge clk);
    @(posedge clk); #1;
    check("R2 next edge", {16'h0, res_o}, 32'h11);
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog got=timeout exp=done");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    rst = 1'b1;
    op_i = '0; dst_i = '0; src_i = '0; imm_i = '0; flags_i = '0;
    @(negedge clk);
    t_reset();
    t_byte_add();
    t_byte_sub();
    t_compare();
    t_imm();
    t_logic();
    t_word();
    t_mixed();
    t_flagmask();
    t_upper_ignored();
    t_latency();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule